// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that two bus masters share: a host processor and a coprocessor core. Each semaphore is free, owned by the host, or owned by the coprocessor. A master uses one to claim a shared resource before it touches that resource, and gives it back when done.

The host reaches the whole bank through one register that is twice as wide as the semaphore count. In a write, the upper half is a per-semaphore enable mask and the lower half carries the request for each semaphore. Only bits whose mask bit is set in that same write have any effect. The coprocessor has its own port. A set request names one semaphore and gets a same-cycle success flag. A clear request names one semaphore and returns no answer.

Both masters may try to lock the same free semaphore in the same cycle. In that case the coprocessor wins by fixed priority and the host attempt is dropped without notice. On a read, the host sees only its own ownership.

Top module: `semabank`

## Requirements
- R1: After a synchronous active-high reset, every semaphore is free and `host_rdata` reads 0x0000.
- R2: A host write changes semaphore i only when mask bit `host_wdata[N+i]` is 1 in that same write. With the mask bit at 0, the data bit is ignored.
- R3: A masked host write of 1 to data bit i locks semaphore i for the host if it is free at the start of the cycle.
- R4: A masked host write of 1 to a semaphore owned by the coprocessor leaves it owned by the coprocessor.
- R5: A masked host write of 0 to data bit i frees semaphore i only if the host owns it. A semaphore owned by the coprocessor stays owned by the coprocessor.
- R6: Read bit i of `host_rdata` is 1 only when the host owns semaphore i. It is 0 when the semaphore is free or owned by the coprocessor. The value is the state registered before the current edge.
- R7: The upper half of `host_rdata`, where the mask bits sit in a write, always reads 0.
- R8: A coprocessor set request on a free semaphore takes it for the coprocessor, and `cop_set_ok` is 1 in the same cycle.
- R9: A coprocessor set request on a semaphore that is not free leaves the state unchanged, and `cop_set_ok` is 0 in the same cycle.
- R10: A coprocessor clear request frees the named semaphore only if the coprocessor owns it. Otherwise it has no effect.
- R11: If the host and the coprocessor both try to lock the same free semaphore in one cycle, the coprocessor gets it and the host attempt is dropped.
- R12: The semaphores are independent. One host write may lock some semaphores and release others together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Register select for the host access |
| host_wr | input | 1 | Host write strobe; acts only together with host_sel |
| host_wdata | input | 2*N | Upper half: write mask; lower half: lock (1) or release (0) requests |
| host_rdata | output | 2*N | Lower half: host ownership per semaphore; upper half: zero |
| cop_set_req | input | 1 | Coprocessor request to lock a semaphore |
| cop_set_idx | input | log2(N) | Index of the semaphore to lock |
| cop_set_ok | output | 1 | Same-cycle result of the set request: 1 when granted |
| cop_clr_req | input | 1 | Coprocessor request to release a semaphore |
| cop_clr_idx | input | log2(N) | Index of the semaphore to release |

## Verification
The in-design properties assume two things about the inputs: the coprocessor indices stay within the semaphore count, and reset is held through at least one rising edge before operations begin. The stimulus drives only indices 0 to 7 with the default count. It releases reset on a falling edge after several edges with reset high. The sequences are built so that each ownership transition, including the tied lock attempt, happens from a known state that the bench model tracks.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_HOST = 2'd1,
      OWN_COP  = 2'd2
   } owner_e;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   host_lock,
   input  logic   host_rel,
   input  logic   cop_set,
   input  logic   cop_clr,
   output logic   cop_grant,
   output logic   host_owns
);
   owner_e owner_q, owner_d;

   always_comb begin
      owner_d = owner_q;
      unique case (owner_q)
         OWN_FREE: begin
            if (cop_set)        owner_d = OWN_COP;   // fixed priority: coprocessor first
            else if (host_lock) owner_d = OWN_HOST;
         end
         OWN_HOST: if (host_rel) owner_d = OWN_FREE;
         OWN_COP:  if (cop_clr)  owner_d = OWN_FREE;
         default:  owner_d = OWN_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) owner_q <= OWN_FREE;
      else     owner_q <= owner_d;
   end

   assign cop_grant = cop_set && (owner_q == OWN_FREE);
   assign host_owns = (owner_q == OWN_HOST);

   // R8: a granted set leaves the cell with the coprocessor
   a_r8_grant_takes: assert property (@(posedge clk) disable iff (rst)
      cop_grant |=> owner_q == OWN_COP);
   // R4 / R5: coprocessor ownership survives any host request
   a_r5_cop_kept: assert property (@(posedge clk) disable iff (rst)
      (owner_q == OWN_COP && !cop_clr) |=> owner_q == OWN_COP);
   // R10: coprocessor clear cannot free a host-held cell
   a_r10_host_kept: assert property (@(posedge clk) disable iff (rst)
      (owner_q == OWN_HOST && !host_rel) |=> owner_q == OWN_HOST);
   // R11: a tied lock goes to the coprocessor
   a_r11_tie_cop: assert property (@(posedge clk) disable iff (rst)
      (owner_q == OWN_FREE && cop_set && host_lock) |=> owner_q == OWN_COP);
   // R3: an uncontested host lock on a free cell succeeds
   a_r3_host_takes: assert property (@(posedge clk) disable iff (rst)
      (owner_q == OWN_FREE && !cop_set && host_lock) |=> host_owns);
endmodule

// File: rtl/sem_host_port.sv
module sem_host_port #(
   parameter int unsigned NUM_SEM = 8,
   localparam int unsigned REG_W  = 2 * NUM_SEM
) (
   input  logic               host_sel,
   input  logic               host_wr,
   input  logic [REG_W-1:0]   host_wdata,
   input  logic [NUM_SEM-1:0] held_by_host,
   output logic [NUM_SEM-1:0] lock_req,
   output logic [NUM_SEM-1:0] rel_req,
   output logic [REG_W-1:0]   host_rdata
);
   logic                 we;
   logic [NUM_SEM-1:0]   mask;
   logic [NUM_SEM-1:0]   bits;

   assign we   = host_sel & host_wr;
   assign mask = host_wdata[REG_W-1:NUM_SEM];
   assign bits = host_wdata[NUM_SEM-1:0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_bit
      assign lock_req[i] = we &  mask[i] &  bits[i];
      assign rel_req[i]  = we &  mask[i] & ~bits[i];
   end

   assign host_rdata = {{NUM_SEM{1'b0}}, held_by_host};
endmodule

// File: rtl/sem_cop_port.sv
module sem_cop_port #(
   parameter int unsigned NUM_SEM = 8,
   localparam int unsigned IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic               set_req,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr_req,
   input  logic [IDX_W-1:0]   clr_idx,
   input  logic [NUM_SEM-1:0] grant,
   output logic [NUM_SEM-1:0] set_vec,
   output logic [NUM_SEM-1:0] clr_vec,
   output logic               set_ok
);
   for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
      assign set_vec[i] = set_req && (set_idx == IDX_W'(i));
      assign clr_vec[i] = clr_req && (clr_idx == IDX_W'(i));
   end

   assign set_ok = |grant;

   always_comb begin
      a_r9_one_grant: assert ($onehot0(grant));
   end
endmodule

// File: rtl/semabank.sv
module semabank #(
   parameter int unsigned NUM_SEM = 8,
   localparam int unsigned REG_W  = 2 * NUM_SEM,
   localparam int unsigned IDX_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             host_sel,
   input  logic             host_wr,
   input  logic [REG_W-1:0] host_wdata,
   output logic [REG_W-1:0] host_rdata,
   input  logic             cop_set_req,
   input  logic [IDX_W-1:0] cop_set_idx,
   output logic             cop_set_ok,
   input  logic             cop_clr_req,
   input  logic [IDX_W-1:0] cop_clr_idx
);
   if (NUM_SEM < 2 || NUM_SEM > 16) begin : g_bad_count
      $error("semabank: NUM_SEM must lie in 2..16");
   end

   logic [NUM_SEM-1:0] lock_req, rel_req, set_vec, clr_vec, grant, held;

   sem_host_port #(.NUM_SEM(NUM_SEM)) u_host (
      .host_sel     (host_sel),
      .host_wr      (host_wr),
      .host_wdata   (host_wdata),
      .held_by_host (held),
      .lock_req     (lock_req),
      .rel_req      (rel_req),
      .host_rdata   (host_rdata)
   );

   sem_cop_port #(.NUM_SEM(NUM_SEM)) u_cop (
      .set_req (cop_set_req),
      .set_idx (cop_set_idx),
      .clr_req (cop_clr_req),
      .clr_idx (cop_clr_idx),
      .grant   (grant),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .set_ok  (cop_set_ok)
   );

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sem_cell u_cell (
         .clk       (clk),
         .rst       (rst),
         .host_lock (lock_req[i]),
         .host_rel  (rel_req[i]),
         .cop_set   (set_vec[i]),
         .cop_clr   (clr_vec[i]),
         .cop_grant (grant[i]),
         .host_owns (held[i])
      );
   end

   // R1: reset clears every ownership bit
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> host_rdata == '0);
   // R2: without a host write the host view cannot gain bits
   a_r2_no_write_no_gain: assert property (@(posedge clk) disable iff (rst)
      !(host_sel && host_wr) |=> (host_rdata & ~$past(host_rdata)) == '0);
   // R7: mask half never shows up in the readback
   a_r7_mask_zero: assert property (@(posedge clk) disable iff (rst)
      host_sel |=> host_rdata[REG_W-1:NUM_SEM] == '0);
endmodule

// File: tb/tb_semabank.sv
module tb_semabank;
   localparam int N = 8;

   typedef struct {
      logic [15:0] v;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        cop_set_req = 1'b0, cop_clr_req = 1'b0;
   logic [2:0]  cop_set_idx = '0, cop_clr_idx = '0;
   logic        cop_set_ok;

   int compared = 0, mismatched = 0;
   int own [N];           // 0 free, 1 host, 2 coprocessor
   item_t rd_q[$];
   item_t ok_q[$];
   event  ok_ev;
   bit    done = 1'b0;

   always #5 clk = ~clk;

   semabank dut (
      .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cop_set_req(cop_set_req), .cop_set_idx(cop_set_idx), .cop_set_ok(cop_set_ok),
      .cop_clr_req(cop_clr_req), .cop_clr_idx(cop_clr_idx)
   );

   function automatic logic [15:0] model_view();
      logic [15:0] r = '0;
      for (int i = 0; i < N; i++) r[i] = (own[i] == 1);
      return r;
   endfunction

   task automatic step(input bit wr, input logic [15:0] wd,
                       input bit cs, input int csi,
                       input bit cc, input int cci, input string tag);
      int    pre [N];
      item_t it;
      @(negedge clk);
      host_sel = wr; host_wr = wr; host_wdata = wd;
      cop_set_req = cs; cop_set_idx = 3'(csi);
      cop_clr_req = cc; cop_clr_idx = 3'(cci);
      for (int i = 0; i < N; i++) pre[i] = own[i];
      if (cs) begin
         it.v = {15'd0, (pre[csi] == 0)};
         it.tag = tag;
         ok_q.push_back(it);
         -> ok_ev;
      end
      for (int i = 0; i < N; i++) begin
         if (pre[i] == 0) begin
            if (cs && csi == i)                  own[i] = 2;
            else if (wr && wd[N+i] && wd[i])     own[i] = 1;
         end else if (pre[i] == 1) begin
            if (wr && wd[N+i] && !wd[i])         own[i] = 0;
         end else begin
            if (cc && cci == i)                  own[i] = 0;
         end
      end
      @(posedge clk);
      it.v = model_view();
      it.tag = tag;
      rd_q.push_back(it);
   endtask

   // monitor: same-cycle set result
   initial forever begin
      item_t e;
      @(ok_ev);
      #1;
      e = ok_q.pop_front();
      compared++;
      if (cop_set_ok !== e.v[0]) begin
         mismatched++;
         $display("FAIL %s cop_set_ok actual=%0b expected=%0b", e.tag, cop_set_ok, e.v[0]);
      end
   end

   // monitor: registered host view
   always @(negedge clk) begin
      if (rd_q.size() > 0) begin
         item_t e;
         e = rd_q.pop_front();
         compared++;
         if (host_rdata !== e.v) begin
            mismatched++;
            $display("FAIL %s host_rdata actual=%h expected=%h", e.tag, host_rdata, e.v);
         end
      end
   end

   initial begin
      for (int i = 0; i < N; i++) own[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      step(0, 16'h0000, 0, 0, 0, 0, "R1 reset view");
      step(1, 16'h00FF, 0, 0, 0, 0, "R2 unmasked write ignored");
      step(1, 16'h0101, 0, 0, 0, 0, "R3 host lock free");
      step(1, 16'hFFA0, 0, 0, 0, 0, "R12 R7 mixed lock and release");
      step(0, 16'h0000, 1, 2, 0, 0, "R8 R6 cop takes free");
      step(0, 16'h0000, 1, 5, 0, 0, "R9 cop set on host-held");
      step(1, 16'h0404, 0, 0, 0, 0, "R4 host lock on cop-held");
      step(1, 16'h0400, 1, 2, 0, 0, "R5 host release of cop-held");
      step(0, 16'h0000, 0, 0, 1, 5, "R10 cop clear of host-held");
      step(0, 16'h0000, 0, 0, 1, 2, "R10 cop clear own");
      step(1, 16'h0404, 0, 0, 0, 0, "R10 freed then host lock");
      step(1, 16'h0808, 1, 3, 0, 0, "R11 tie goes to cop");
      step(1, 16'h0808, 0, 0, 1, 3, "R11 host blocked in same cycle as clear");
      step(1, 16'h0808, 0, 0, 0, 0, "R3 host lock after clear");
      step(1, 16'h8000, 0, 0, 0, 0, "R5 host release own");
      step(0, 16'h0000, 1, 7, 0, 0, "R8 cop takes released");
      step(1, 16'hFF00, 1, 7, 0, 0, "R9 R6 cop-held not shown to host");
      step(0, 16'h0000, 0, 0, 0, 0, "R1 idle");
      repeat (2) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            mismatched++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule